// File: doc/BRIEF.md
# NAND Two-Phase Transaction Sequencer

This block converts single-beat bus transfers into the pin activity of an 8-bit NAND flash. The bus address is not a plain location. It encodes what kind of flash operation to run. Bit 19 selects the phase. A command phase sends a start opcode with the command latch enable high. It then sends zero to seven address bytes with the address latch enable high, and can finish with a second opcode. A data phase moves one byte to or from the flash. It can then close the transfer: it sends a closing opcode and releases chip enable.

Every byte is framed by a low pulse on the write or read strobe, and each pulse lasts a fixed number of clock cycles. A command phase can end with a closing opcode, which usually starts an array operation. In that case the next data-phase read waits for the ready/busy line to go low and then high again. Chip enable is asserted by the first transaction. It stays asserted across any number of transactions until a data phase asks for its release.

Top module: `nand_phase_seq`

## Requirements
- R1: After reset, chip enable is high (inactive), both strobes are high, both latch enables are low, the IO output enable is low and `bus_ready` is low.
- R2: A transaction with address bit 19 = 0 (command phase) first latches the byte in address bits [10:3] on a write-strobe rising edge, with the command latch enable high and the address latch enable low. The two latch enables are never high together.
- R3: In a command phase, address bits [23:21] give a count N (0 to 7). After the start opcode, N bytes are latched with the address latch enable high and the command latch enable low. They are taken from the write data, bits [7:0] first and then each next higher byte.
- R4: In a command phase with address bit 20 = 1, the byte in address bits [18:11] is latched as a command after the address bytes. With bit 20 = 0, no further byte is latched.
- R5: Every write or read strobe is low for exactly PULSE_W consecutive clock cycles per byte (default 2). The two strobes are never low together.
- R6: A data-phase write (bit 19 = 1, `bus_write` = 1) latches write data bits [7:0] with both latch enables low. A data-phase read pulses the read strobe and returns the IO input byte sampled during the last low cycle of that strobe on `bus_rdata`. IO output enable is low while the read strobe is low and high on every write-strobe edge.
- R7: Chip enable goes low when a transaction is accepted and stays low across transactions. It goes high only when a data phase with address bit 21 = 1 completes. Chip enable is low during every strobe.
- R8: A data phase with bits 21 and 20 both set latches the command in bits [18:11] after the data byte and before chip enable rises. In a data phase, bit 20 without bit 21 latches no extra byte.
- R9: `ecc_last_flag` equals address bit 10 while a data-phase strobe is low. It is low during every command-phase strobe.
- R10: After a command phase that latched a closing opcode, the next data-phase read issues no read strobe until the ready/busy input has been seen low and then high. Data-phase writes are not delayed by it.
- R11: Address bits [31:24] and [2:0] in both phases, and bits [23:22] and [9:3] in a data phase, do not change the pin sequence.
- R12: `bus_ready` is high for exactly one cycle per transaction, after the last strobe (and any chip-enable release). `bus_rdata` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Transaction request, held until `bus_ready` |
| bus_write | input | 1 | 1 = write transfer, 0 = read transfer |
| bus_addr | input | 32 | Encoded operation address |
| bus_wdata | input | DATA_W | Address bytes (command phase) or write byte in [7:0] (data phase) |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 8 | Byte read from the flash |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | IO bus output value |
| nand_io_oe | output | 1 | IO bus output enable |
| nand_io_in | input | 8 | IO bus input value |
| nand_rb_n | input | 1 | Ready/busy from the flash, low = busy |
| ecc_last_flag | output | 1 | Data-phase final-transfer flag forwarded from address bit 10 |

## Verification
The command phase is swept over every address-cycle count from 0 to 7, each with and without a closing opcode. The opcodes, data bytes, chip address and reserved bits change from step to step. This separates a wrong count, a wrong byte order or a missing closing opcode. Data writes and reads toggle the final-transfer flag and the reserved bits, and reads return several distinct flash bytes. The four combinations of release and closing-opcode bits separate release ordering from opcode issue. A read after a busy-causing command is held while the ready/busy line is still high or low. The bench checks that no read strobe appears until the high-low-high sequence completes, and that a write in the same situation goes straight through.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int BYTE_W = 8;

  // Operation fields decoded from the bus address
  typedef struct packed {
    logic              is_data;
    logic [BYTE_W-1:0] start_cmd;
    logic [2:0]        n_addr;
    logic              end_valid;
    logic [BYTE_W-1:0] end_cmd;
    logic              clear_cs;
    logic              ecc_last;
  } nand_req_t;

  typedef enum logic [1:0] {
    BYTE_CMD  = 2'd0,
    BYTE_ADDR = 2'd1,
    BYTE_WR   = 2'd2,
    BYTE_RD   = 2'd3
  } byte_kind_t;

endpackage

// File: rtl/nand_addr_decode.sv
module nand_addr_decode
  import nand_seq_pkg::*;
(
  input  logic [31:0] addr,
  output nand_req_t   req
);

  // Chip address and low reserved bits carry no function here
  wire unused_bits = ^{addr[31:24], addr[2:0]};

  always_comb begin
    req.is_data   = addr[19];
    req.start_cmd = addr[10:3];
    req.n_addr    = addr[19] ? 3'd0 : addr[23:21];
    req.end_valid = addr[20];
    req.end_cmd   = addr[18:11];
    req.clear_cs  = addr[19] & addr[21];
    req.ecc_last  = addr[19] & addr[10];
  end

endmodule

// File: rtl/nand_strobe_engine.sv
module nand_strobe_engine
  import nand_seq_pkg::*;
#(
  parameter int PULSE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  byte_kind_t        kind,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [BYTE_W-1:0] io_in,
  output logic              busy,
  output logic              done,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic [BYTE_W-1:0] io_out,
  output logic              io_oe,
  output logic [BYTE_W-1:0] rd_byte
);

  localparam int CNT_W = $clog2(PULSE_W + 1) + 1;

  typedef enum logic [1:0] {E_IDLE, E_SETUP, E_PULSE, E_HOLD} est_t;

  est_t             st;
  logic [CNT_W-1:0] cnt;
  byte_kind_t       kind_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= E_IDLE;
      cnt     <= '0;
      kind_r  <= BYTE_CMD;
      cle     <= 1'b0;
      ale     <= 1'b0;
      we_n    <= 1'b1;
      re_n    <= 1'b1;
      io_out  <= '0;
      io_oe   <= 1'b0;
      rd_byte <= '0;
    end else begin
      case (st)
        E_IDLE: if (start) begin
          st     <= E_SETUP;
          kind_r <= kind;
          io_out <= byte_in;
          cle    <= (kind == BYTE_CMD);
          ale    <= (kind == BYTE_ADDR);
          io_oe  <= (kind != BYTE_RD);
        end
        E_SETUP: begin
          st  <= E_PULSE;
          cnt <= CNT_W'(1);
          if (kind_r == BYTE_RD) re_n <= 1'b0;
          else                   we_n <= 1'b0;
        end
        E_PULSE: begin
          if (cnt == CNT_W'(PULSE_W)) begin
            st   <= E_HOLD;
            we_n <= 1'b1;
            re_n <= 1'b1;
            if (kind_r == BYTE_RD) rd_byte <= io_in;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          st    <= E_IDLE;
          cle   <= 1'b0;
          ale   <= 1'b0;
          io_oe <= 1'b0;
        end
      endcase
    end
  end

  assign busy = (st != E_IDLE);
  assign done = (st == E_HOLD);

  // Checker: width of each low strobe
  logic [CNT_W:0] chk_low;
  always_ff @(posedge clk) begin
    if (rst)                chk_low <= '0;
    else if (!we_n || !re_n) chk_low <= chk_low + 1'b1;
    else                    chk_low <= '0;
  end

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (rst)
    (we_n && re_n && chk_low != 0) |-> (chk_low == (CNT_W+1)'(PULSE_W)));

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));

  assert_latch_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(cle && ale));

  assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (rst)
    !re_n |-> !io_oe);

endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  nand_req_t         req,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic [BYTE_W-1:0] eng_rd_byte,
  input  logic              rb_sync,
  output logic              eng_start,
  output byte_kind_t        eng_kind,
  output logic [BYTE_W-1:0] eng_byte,
  output logic              ce_n,
  output logic              ecc_last,
  output logic              bus_ready,
  output logic [BYTE_W-1:0] bus_rdata
);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD_START, S_ADDR, S_CMD_END, S_BUSY_LO, S_BUSY_HI,
    S_DATA, S_DEND, S_RELEASE, S_ACK
  } st_t;

  st_t               state;
  nand_req_t         req_r;
  logic              wr_r;
  logic [DATA_W-1:0] byte_sh;
  logic [2:0]        cnt_r;
  logic              need_busy;
  logic              launched;

  logic byte_state;
  assign byte_state = (state == S_CMD_START) || (state == S_ADDR) ||
                      (state == S_CMD_END)   || (state == S_DATA) ||
                      (state == S_DEND);
  assign eng_start  = byte_state && !eng_busy && !launched;

  always_comb begin
    eng_kind = BYTE_CMD;
    eng_byte = req_r.start_cmd;
    case (state)
      S_ADDR: begin
        eng_kind = BYTE_ADDR;
        eng_byte = byte_sh[BYTE_W-1:0];
      end
      S_CMD_END, S_DEND: eng_byte = req_r.end_cmd;
      S_DATA: begin
        eng_kind = wr_r ? BYTE_WR : BYTE_RD;
        eng_byte = byte_sh[BYTE_W-1:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      req_r     <= '0;
      wr_r      <= 1'b0;
      byte_sh   <= '0;
      cnt_r     <= '0;
      need_busy <= 1'b0;
      launched  <= 1'b0;
      ce_n      <= 1'b1;
      ecc_last  <= 1'b0;
      bus_rdata <= '0;
    end else begin
      ecc_last <= (state == S_DATA) && req_r.ecc_last;
      if (eng_start)     launched <= 1'b1;
      else if (eng_done) launched <= 1'b0;

      case (state)
        S_IDLE: if (bus_valid) begin
          req_r   <= req;
          wr_r    <= bus_write;
          byte_sh <= bus_wdata;
          cnt_r   <= req.n_addr;
          ce_n    <= 1'b0;
          if (req.is_data) begin
            state <= (!bus_write && need_busy) ? S_BUSY_LO : S_DATA;
          end else begin
            need_busy <= 1'b0;
            state     <= S_CMD_START;
          end
        end
        S_CMD_START: if (eng_done) begin
          if (req_r.n_addr != 3'd0)  state <= S_ADDR;
          else if (req_r.end_valid)  state <= S_CMD_END;
          else                       state <= S_ACK;
        end
        S_ADDR: if (eng_done) begin
          byte_sh <= byte_sh >> BYTE_W;
          cnt_r   <= cnt_r - 1'b1;
          if (cnt_r == 3'd1) state <= req_r.end_valid ? S_CMD_END : S_ACK;
        end
        S_CMD_END: if (eng_done) begin
          need_busy <= 1'b1;
          state     <= S_ACK;
        end
        S_BUSY_LO: if (!rb_sync) state <= S_BUSY_HI;
        S_BUSY_HI: if (rb_sync) begin
          need_busy <= 1'b0;
          state     <= S_DATA;
        end
        S_DATA: if (eng_done) begin
          if (!wr_r) bus_rdata <= eng_rd_byte;
          if (req_r.clear_cs) state <= req_r.end_valid ? S_DEND : S_RELEASE;
          else                state <= S_ACK;
        end
        S_DEND:    if (eng_done) state <= S_RELEASE;
        S_RELEASE: begin
          ce_n  <= 1'b1;
          state <= S_ACK;
        end
        default:   state <= S_IDLE;
      endcase
    end
  end

  assign bus_ready = (state == S_ACK);

  assert_ce_low_in_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    eng_busy |-> !ce_n);

  assert_hold_while_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (state == S_BUSY_LO || state == S_BUSY_HI) |-> !eng_busy);

  assert_ready_single_R12: assert property (@(posedge clk) disable iff (rst)
    bus_ready |=> !bus_ready);

endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nand_seq_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int PULSE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [31:0]       bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ready,
  output logic [7:0]        bus_rdata,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_io_out,
  output logic              nand_io_oe,
  input  logic [7:0]        nand_io_in,
  input  logic              nand_rb_n,
  output logic              ecc_last_flag
);

  nand_req_t         req;
  logic              eng_start, eng_busy, eng_done;
  byte_kind_t        eng_kind;
  logic [BYTE_W-1:0] eng_byte, eng_rd_byte;
  logic [1:0]        rb_meta;

  always_ff @(posedge clk) begin
    if (rst) rb_meta <= 2'b11;
    else     rb_meta <= {rb_meta[0], nand_rb_n};
  end

  nand_addr_decode u_decode (
    .addr (bus_addr),
    .req  (req)
  );

  nand_seq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .req         (req),
    .bus_wdata   (bus_wdata),
    .eng_busy    (eng_busy),
    .eng_done    (eng_done),
    .eng_rd_byte (eng_rd_byte),
    .rb_sync     (rb_meta[1]),
    .eng_start   (eng_start),
    .eng_kind    (eng_kind),
    .eng_byte    (eng_byte),
    .ce_n        (nand_ce_n),
    .ecc_last    (ecc_last_flag),
    .bus_ready   (bus_ready),
    .bus_rdata   (bus_rdata)
  );

  nand_strobe_engine #(.PULSE_W(PULSE_W)) u_engine (
    .clk     (clk),
    .rst     (rst),
    .start   (eng_start),
    .kind    (eng_kind),
    .byte_in (eng_byte),
    .io_in   (nand_io_in),
    .busy    (eng_busy),
    .done    (eng_done),
    .cle     (nand_cle),
    .ale     (nand_ale),
    .we_n    (nand_we_n),
    .re_n    (nand_re_n),
    .io_out  (nand_io_out),
    .io_oe   (nand_io_oe),
    .rd_byte (eng_rd_byte)
  );

endmodule

// File: tb/nand_phase_seq_tb.sv
`timescale 1ns/1ps
module nand_phase_seq_tb;

  localparam int DW = 64;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_valid = 1'b0, bus_write = 1'b0;
  logic [31:0]   bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_ready;
  logic [7:0]    bus_rdata;
  logic          nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0]    nand_io_out;
  logic [7:0]    io_in_r = '0;
  logic          rb_n = 1'b1;
  logic          ecc_last_flag;

  always #4 clk = ~clk;

  nand_phase_seq #(.DATA_W(DW), .PULSE_W(PW)) u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(io_in_r),
    .nand_rb_n(rb_n), .ecc_last_flag(ecc_last_flag)
  );

  int checks = 0, errors = 0;
  int mon_chk = 0, mon_err = 0;
  logic [7:0] rd_val = 8'h00;

  // Flash-side monitor: log every write-strobe rising edge
  logic [1:0]  lk [256];
  logic [7:0]  lb [256];
  logic        le [256];
  int unsigned log_len = 0;
  int unsigned re_count = 0;
  int wlow = 0, rlow = 0;
  logic prev_we = 1'b1, prev_re = 1'b1, last_re_ecc = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!nand_we_n) wlow++;
      else if (wlow != 0) begin
        mon_chk++;
        if (wlow != PW) begin mon_err++; $display("FAIL R5 we low actual %0d expected %0d", wlow, PW); end
        wlow = 0;
      end
      if (!nand_re_n) rlow++;
      else if (rlow != 0) begin
        mon_chk++;
        if (rlow != PW) begin mon_err++; $display("FAIL R5 re low actual %0d expected %0d", rlow, PW); end
        rlow = 0;
      end
      if (!prev_we && nand_we_n) begin
        lk[log_len[7:0]] = nand_cle ? 2'd1 : (nand_ale ? 2'd2 : 2'd0);
        lb[log_len[7:0]] = nand_io_out;
        le[log_len[7:0]] = ecc_last_flag;
        log_len++;
        mon_chk++;
        if (!nand_io_oe || (nand_cle && nand_ale) || nand_ce_n) begin
          mon_err++; $display("FAIL R6 oe/latch/ce at write edge actual %b%b%b%b expected 1x0", nand_io_oe, nand_cle, nand_ale, nand_ce_n);
        end
      end
      if (prev_re && !nand_re_n) begin
        re_count++;
        io_in_r = rd_val;
        mon_chk++;
        if (nand_io_oe || nand_ce_n) begin mon_err++; $display("FAIL R6 oe/ce during read actual %b%b expected 00", nand_io_oe, nand_ce_n); end
      end
      if (!prev_re && nand_re_n) last_re_ecc = ecc_last_flag;
      prev_we = nand_we_n;
      prev_re = nand_re_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic txn(input logic wr, input logic [31:0] a, input logic [63:0] d,
                     output logic [7:0] rd, output int cyc);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d; cyc = 0;
    do begin @(negedge clk); cyc++; end while (!bus_ready);
    rd = bus_rdata;
    bus_valid = 1'b0;
    @(negedge clk);
    chk(!bus_ready, "R12 ready one cycle", 64'(bus_ready), 64'd0);
  endtask

  function automatic logic [31:0] cmd_addr(input logic [7:0] chip, input int n, input bit ev,
                                           input logic [7:0] ec, input logic [7:0] sc, input logic [2:0] rs);
    return {chip, 3'(n), ev, 1'b0, ec, sc, rs};
  endfunction

  function automatic logic [31:0] data_addr(input logic [7:0] chip, input logic [1:0] r2, input bit clr,
                                            input bit ev, input logic [7:0] ec, input bit ecc,
                                            input logic [6:0] r7, input logic [2:0] rs);
    return {chip, r2, clr, ev, 1'b1, ec, ecc, r7, rs};
  endfunction

  task automatic run_cmd(input int n, input bit ev, input logic [7:0] sc, input logic [7:0] ec,
                         input logic [63:0] d, input logic [7:0] chip, input logic [2:0] rs);
    int unsigned base;
    logic [7:0] rd;
    int cyc;
    base = log_len;
    txn(1'b1, cmd_addr(chip, n, ev, ec, sc, rs), d, rd, cyc);
    chk(log_len - base == 32'(1 + n + int'(ev)), "R3/R4 byte count", 64'(log_len - base), 64'(1 + n + int'(ev)));
    chk(lk[8'(base)] == 2'd1 && lb[8'(base)] == sc, "R2 start opcode", {lk[8'(base)], lb[8'(base)]}, {2'd1, sc});
    for (int i = 0; i < n; i++) begin
      chk(lk[8'(base+1+i)] == 2'd2 && lb[8'(base+1+i)] == d[8*i +: 8], "R3 address byte",
          {lk[8'(base+1+i)], lb[8'(base+1+i)]}, {2'd2, d[8*i +: 8]});
    end
    if (ev) chk(lk[8'(base+1+n)] == 2'd1 && lb[8'(base+1+n)] == ec, "R4 closing opcode",
                {lk[8'(base+1+n)], lb[8'(base+1+n)]}, {2'd1, ec});
    for (int i = 0; i < 1 + n + int'(ev); i++)
      chk(le[8'(base+i)] == 1'b0, "R9 flag low in command phase", 64'(le[8'(base+i)]), 64'd0);
    chk(nand_ce_n == 1'b0, "R7 ce held low", 64'(nand_ce_n), 64'd0);
  endtask

  initial begin
    logic [7:0] rd;
    int cyc;
    int unsigned base;
    int unsigned rc0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe && !bus_ready,
        "R1 reset state", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe, bus_ready}, 7'b1110000);

    // R2 R3 R4 R11: sweep of counts and closing opcode
    for (int n = 0; n < 8; n++) begin
      for (int e = 0; e < 2; e++) begin
        run_cmd(n, e[0], 8'(8'h10 + n*2 + e), 8'(8'hE0 ^ n),
                {8{8'(n*17 + e)}} ^ 64'h0123_4567_89AB_CDEF, 8'(n*31), 3'(n));
      end
    end

    // R6 R9 R10 R11: data writes, not delayed by the pending busy wait
    for (int k = 0; k < 4; k++) begin
      base = log_len;
      txn(1'b1, data_addr(8'(k*77), 2'(k), 1'b0, 1'b0, 8'h00, k[0], 7'(k*37), 3'(k)),
          64'(8'hA0 + k*9), rd, cyc);
      chk(log_len - base == 1, "R6 one data byte", 64'(log_len - base), 64'd1);
      chk(lk[8'(base)] == 2'd0 && lb[8'(base)] == 8'(8'hA0 + k*9), "R6 write byte",
          {lk[8'(base)], lb[8'(base)]}, {2'd0, 8'(8'hA0 + k*9)});
      chk(le[8'(base)] == k[0], "R9 flag on data write", 64'(le[8'(base)]), 64'(k[0]));
      chk(cyc < PW + 8, "R10 write not delayed", 64'(cyc), 64'(PW + 8));
      chk(nand_ce_n == 1'b0, "R7 ce low after write", 64'(nand_ce_n), 64'd0);
    end

    // R10: read after busy-causing command waits for low then high
    run_cmd(5, 1'b1, 8'h00, 8'h30, 64'h0000_00EE_DDCC_BBAA, 8'h00, 3'd0);
    rc0 = re_count;
    rd_val = 8'h5C;
    fork
      txn(1'b0, data_addr(8'h00, 2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 7'd0, 3'd0), 64'd0, rd, cyc);
      begin
        repeat (20) @(negedge clk);
        chk(re_count == rc0, "R10 no read while ready high", 64'(re_count - rc0), 64'd0);
        rb_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(re_count == rc0, "R10 no read while busy", 64'(re_count - rc0), 64'd0);
        rb_n = 1'b1;
      end
    join
    chk(re_count == rc0 + 1, "R10 read issued after ready", 64'(re_count - rc0), 64'd1);
    chk(rd == 8'h5C, "R6 read byte", 64'(rd), 64'h5C);
    chk(last_re_ecc == 1'b1, "R9 flag on data read", 64'(last_re_ecc), 64'd1);

    // R6 R9: reads with no pending busy wait
    for (int k = 0; k < 4; k++) begin
      rd_val = 8'(8'h3B * (k + 1));
      txn(1'b0, data_addr(8'hFF, 2'(3 - k), 1'b0, 1'b0, 8'h00, k[1], 7'h7F, 3'd7), 64'd0, rd, cyc);
      chk(rd == 8'(8'h3B * (k + 1)), "R6 read byte sweep", 64'(rd), 64'(8'(8'h3B * (k + 1))));
      chk(last_re_ecc == k[1], "R9 flag on read sweep", 64'(last_re_ecc), 64'(k[1]));
    end

    // R8 R7: release with closing opcode
    base = log_len;
    txn(1'b1, data_addr(8'h12, 2'd0, 1'b1, 1'b1, 8'h5A, 1'b0, 7'd0, 3'd0), 64'h77, rd, cyc);
    chk(log_len - base == 2, "R8 data plus closing opcode", 64'(log_len - base), 64'd2);
    chk(lk[8'(base)] == 2'd0 && lb[8'(base)] == 8'h77, "R8 data first", {lk[8'(base)], lb[8'(base)]}, {2'd0, 8'h77});
    chk(lk[8'(base+1)] == 2'd1 && lb[8'(base+1)] == 8'h5A, "R8 opcode second", {lk[8'(base+1)], lb[8'(base+1)]}, {2'd1, 8'h5A});
    chk(nand_ce_n == 1'b1, "R7 ce released", 64'(nand_ce_n), 64'd1);

    // R7: next transaction asserts chip enable again
    run_cmd(2, 1'b0, 8'h90, 8'h00, 64'h0000_0000_0000_4433, 8'h01, 3'd1);

    // R8: closing opcode without release sends nothing extra
    base = log_len;
    txn(1'b1, data_addr(8'h00, 2'd0, 1'b0, 1'b1, 8'hC3, 1'b0, 7'd0, 3'd0), 64'h19, rd, cyc);
    chk(log_len - base == 1, "R8 no opcode without release", 64'(log_len - base), 64'd1);
    chk(nand_ce_n == 1'b0, "R7 ce kept without release", 64'(nand_ce_n), 64'd0);

    // R7: read with release and no opcode
    rd_val = 8'hD4;
    base = log_len;
    txn(1'b0, data_addr(8'h00, 2'd0, 1'b1, 1'b0, 8'hC3, 1'b0, 7'd0, 3'd0), 64'd0, rd, cyc);
    chk(log_len - base == 0, "R7 read release no write edge", 64'(log_len - base), 64'd0);
    chk(rd == 8'hD4, "R6 read before release", 64'(rd), 64'hD4);
    chk(nand_ce_n == 1'b1, "R7 ce released after read", 64'(nand_ce_n), 64'd1);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks + mon_chk, errors + mon_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks + mon_chk + 1, errors + mon_err + 1);
    $finish;
  end

endmodule